// File: doc/BRIEF.md
# Double-Fault Trap Supervisor

This block tracks whether the processor is currently servicing a severe trap. A severe trap is a hardware error, a qualifying instruction exception or a watchdog runout. The first such trap raises a fault-in-progress flag and captures a cause code. While the flag is up, the processor-fault, memory-fault and count-pulse interrupts are held inhibited, whatever the status-word inhibit bits say. The trap routine ends with a status-load instruction, and the decoder presents it to the block together with two mode bits. Only one combination of those bits drops the flag.

A severe trap that arrives while the flag is still set is a double fault. The block then raises a hang output that freezes the processor. The hang stays up until the operator issues a basic-processor reset or a system reset. Either command starts a fixed recovery sequence of one-cycle strobes that steps through the following actions:

- clear the fault status register
- clear the fault-in-progress flag and the processor-fault-interrupt-generated flag
- clear the status words
- load the restart address (hex 26) into the instruction address field
- release the hang

The status-word storage and the interrupt controller sit outside the block and act on these strobes.

Top module: `dfault_supervisor`

## Requirements
- R1: With the flag clear and no recovery sequence running, any bit of `sev_trap_i` sets `fault_flag_o` on the next cycle. The bit assignments are: bit 0 for a hardware error, bit 1 for a qualifying instruction exception, bit 2 for a watchdog runout.
- R2: `fault_status_o` captures `trap_cause_i` on the first severe trap after it was last cleared. Every later cause is ignored until the recovery sequence clears it.
- R3: While `fault_flag_o` is 1, `inh_pf_o`, `inh_mf_o` and every bit of `inh_cp_o` are 1. While it is 0, each of these outputs equals its status-word inhibit input.
- R4: An exit with `exit_b10_i`=0 and `exit_b11_i`=1 clears the flag on the next cycle. The three other bit combinations leave the flag unchanged.
- R5: A severe trap while the flag is set raises `hang_o` on the next cycle. `hang_o` then stays high, and exits are ignored, until the release step of the recovery sequence.
- R6: A severe trap and a qualifying exit in the same cycle, with the flag set, count as a double fault: `hang_o` rises and the flag stays set.
- R7: Either operator reset input, sampled while the block is idle, produces five strobes in the order `clr_status_o`, `clr_flags_o`, `clr_psw_o`, `load_restart_o`, `release_o`. The first strobe appears in the cycle after the request, the strobes run on consecutive cycles, and no two are ever active together.
- R8: `fault_status_o` reads 0 after the status-clear step. The flag and `pf_int_gen_o` read 0 after the flag-clear step. `hang_o` reads 0 after the release step.
- R9: `restart_addr_o` carries 0x26 during `load_restart_o` and 0 in every other cycle.
- R10: While `seq_busy_o` is 1, severe traps, exits and further operator resets have no effect.
- R11: `pf_int_taken_i` sets `pf_int_gen_o`. Only the recovery sequence clears it.
- R12: After reset, the flag, `hang_o`, `fault_status_o`, `pf_int_gen_o` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sev_trap_i | input | N_SEV | Severe trap pulses: bit 0 hardware error, bit 1 instruction exception, bit 2 watchdog runout |
| trap_cause_i | input | FSR_W | Cause code that goes with the trap |
| exit_valid_i | input | 1 | A trap-exit status-load instruction completes |
| exit_b10_i | input | 1 | Mode bit 10 of the exit instruction |
| exit_b11_i | input | 1 | Mode bit 11 of the exit instruction |
| pf_int_taken_i | input | 1 | A processor-fault interrupt was generated |
| op_reset_bp_i | input | 1 | Operator command: reset basic processor |
| op_reset_sys_i | input | 1 | Operator command: reset system |
| psw_inh_pf_i | input | 1 | Status-word inhibit for the processor-fault interrupt |
| psw_inh_mf_i | input | 1 | Status-word inhibit for the memory-fault interrupt |
| psw_inh_cp_i | input | N_CP | Status-word inhibits for the count-pulse interrupts |
| fault_flag_o | output | 1 | Fault-in-progress flag |
| pf_int_gen_o | output | 1 | Processor-fault-interrupt-generated flag |
| fault_status_o | output | FSR_W | Captured cause code |
| hang_o | output | 1 | Processor freeze |
| inh_pf_o | output | 1 | Effective processor-fault inhibit |
| inh_mf_o | output | 1 | Effective memory-fault inhibit |
| inh_cp_o | output | N_CP | Effective count-pulse inhibits |
| clr_status_o | output | 1 | Strobe: fault status register cleared |
| clr_flags_o | output | 1 | Strobe: flags cleared |
| clr_psw_o | output | 1 | Strobe: clear the status words |
| load_restart_o | output | 1 | Strobe: load the restart address |
| restart_addr_o | output | ADDR_W | Restart address, valid with `load_restart_o` |
| release_o | output | 1 | Strobe: hang released |
| seq_busy_o | output | 1 | Recovery sequence running |

## Verification
The bench builds the block with N_CP=2 and keeps the other parameters at their defaults. With that setting, all 16 combinations of the inhibit inputs can be swept with the flag both set and clear. Each of the seven non-empty trap-source patterns is run through a full trap, exit, double-fault and recovery cycle, with a cause code computed from the pattern. All four exit-bit combinations are applied. The bench also covers a simultaneous trap and exit, and a trap injected during the recovery sequence.

// File: rtl/dfs_pkg.sv
`timescale 1ns/1ps
package dfs_pkg;
  localparam int unsigned N_SEV = 3;

  typedef enum logic [2:0] {
    SEQ_IDLE      = 3'd0,
    SEQ_CLR_FSR   = 3'd1,
    SEQ_CLR_FLAGS = 3'd2,
    SEQ_CLR_PSW   = 3'd3,
    SEQ_LOAD_ADDR = 3'd4,
    SEQ_RELEASE   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/dfs_fault_track.sv
`timescale 1ns/1ps
module dfs_fault_track #(
  parameter int unsigned N_SEV = 3,
  parameter int unsigned FSR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SEV-1:0] sev_trap_i,
  input  logic [FSR_W-1:0] trap_cause_i,
  input  logic             exit_valid_i,
  input  logic             exit_b10_i,
  input  logic             exit_b11_i,
  input  logic             pf_int_taken_i,
  input  logic             busy_i,
  input  logic             clr_status_i,
  input  logic             clr_flags_i,
  input  logic             release_i,
  output logic             flag_o,
  output logic             pf_gen_o,
  output logic             hang_o,
  output logic [FSR_W-1:0] fsr_o
);
  logic             flag_q, hang_q, pf_gen_q, fsr_full_q;
  logic [FSR_W-1:0] fsr_q;
  logic             trap_any, exit_clr;

  // events are dropped while recovery runs; exits also while frozen
  assign trap_any = (|sev_trap_i) && !busy_i;
  assign exit_clr = exit_valid_i && !exit_b10_i && exit_b11_i && !busy_i && !hang_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (clr_flags_i) begin
      flag_q <= 1'b0;
    end else if (trap_any) begin
      flag_q <= 1'b1;
    end else if (exit_clr) begin
      flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hang_q <= 1'b0;
    end else if (release_i) begin
      hang_q <= 1'b0;
    end else if (trap_any && flag_q) begin
      hang_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_q      <= '0;
      fsr_full_q <= 1'b0;
    end else if (clr_status_i) begin
      fsr_q      <= '0;
      fsr_full_q <= 1'b0;
    end else if (trap_any && !fsr_full_q) begin
      fsr_q      <= trap_cause_i;
      fsr_full_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_gen_q <= 1'b0;
    end else if (clr_flags_i) begin
      pf_gen_q <= 1'b0;
    end else if (pf_int_taken_i) begin
      pf_gen_q <= 1'b1;
    end
  end

  assign flag_o   = flag_q;
  assign hang_o   = hang_q;
  assign fsr_o    = fsr_q;
  assign pf_gen_o = pf_gen_q;

  p_flag_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_any && !flag_q) |=> flag_q);
  p_fsr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fsr_full_q && !clr_status_i) |=> $stable(fsr_q));
  p_exit_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_clr && flag_q && !trap_any && !clr_flags_i) |=> !flag_q);
  p_hang_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_any && flag_q) |=> hang_q);
  p_hang_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hang_q && !release_i) |=> hang_q);
  p_dual_fault_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_any && exit_clr && flag_q) |=> (flag_q && hang_q));
  p_busy_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !release_i) |=> $stable(hang_q));
endmodule

// File: rtl/dfs_reset_seq.sv
`timescale 1ns/1ps
module dfs_reset_seq
  import dfs_pkg::*;
#(
  parameter int unsigned ADDR_W       = 17,
  parameter logic [ADDR_W-1:0] RESTART_ADDR = 'h26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_reset_bp_i,
  input  logic              op_reset_sys_i,
  output logic              busy_o,
  output logic              clr_status_o,
  output logic              clr_flags_o,
  output logic              clr_psw_o,
  output logic              load_restart_o,
  output logic [ADDR_W-1:0] restart_addr_o,
  output logic              release_o
);
  seq_state_e state_q, state_d;
  logic       op_any;

  assign op_any = op_reset_bp_i || op_reset_sys_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:      if (op_any) state_d = SEQ_CLR_FSR;
      SEQ_CLR_FSR:   state_d = SEQ_CLR_FLAGS;
      SEQ_CLR_FLAGS: state_d = SEQ_CLR_PSW;
      SEQ_CLR_PSW:   state_d = SEQ_LOAD_ADDR;
      SEQ_LOAD_ADDR: state_d = SEQ_RELEASE;
      SEQ_RELEASE:   state_d = SEQ_IDLE;
      default:       state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o         = (state_q != SEQ_IDLE);
  assign clr_status_o   = (state_q == SEQ_CLR_FSR);
  assign clr_flags_o    = (state_q == SEQ_CLR_FLAGS);
  assign clr_psw_o      = (state_q == SEQ_CLR_PSW);
  assign load_restart_o = (state_q == SEQ_LOAD_ADDR);
  assign release_o      = (state_q == SEQ_RELEASE);
  assign restart_addr_o = load_restart_o ? RESTART_ADDR : '0;

  p_strobe_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({clr_status_o, clr_flags_o, clr_psw_o, load_restart_o, release_o}));
  p_seq_start_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && op_any) |=> clr_status_o);
  p_seq_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_psw_o |=> load_restart_o);
endmodule

// File: rtl/dfs_inhibit.sv
`timescale 1ns/1ps
module dfs_inhibit #(
  parameter int unsigned N_CP = 4
) (
  input  logic            force_i,
  input  logic            psw_pf_i,
  input  logic            psw_mf_i,
  input  logic [N_CP-1:0] psw_cp_i,
  output logic            pf_o,
  output logic            mf_o,
  output logic [N_CP-1:0] cp_o
);
  assign pf_o = psw_pf_i || force_i;
  assign mf_o = psw_mf_i || force_i;

  for (genvar i = 0; i < N_CP; i++) begin : g_cp
    assign cp_o[i] = psw_cp_i[i] || force_i;
  end
endmodule

// File: rtl/dfault_supervisor.sv
`timescale 1ns/1ps
module dfault_supervisor
  import dfs_pkg::*;
#(
  parameter int unsigned FSR_W  = 8,
  parameter int unsigned N_CP   = 4,
  parameter int unsigned ADDR_W = 17,
  parameter logic [ADDR_W-1:0] RESTART_ADDR = 'h26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SEV-1:0]  sev_trap_i,
  input  logic [FSR_W-1:0]  trap_cause_i,
  input  logic              exit_valid_i,
  input  logic              exit_b10_i,
  input  logic              exit_b11_i,
  input  logic              pf_int_taken_i,
  input  logic              op_reset_bp_i,
  input  logic              op_reset_sys_i,
  input  logic              psw_inh_pf_i,
  input  logic              psw_inh_mf_i,
  input  logic [N_CP-1:0]   psw_inh_cp_i,
  output logic              fault_flag_o,
  output logic              pf_int_gen_o,
  output logic [FSR_W-1:0]  fault_status_o,
  output logic              hang_o,
  output logic              inh_pf_o,
  output logic              inh_mf_o,
  output logic [N_CP-1:0]   inh_cp_o,
  output logic              clr_status_o,
  output logic              clr_flags_o,
  output logic              clr_psw_o,
  output logic              load_restart_o,
  output logic [ADDR_W-1:0] restart_addr_o,
  output logic              release_o,
  output logic              seq_busy_o
);
  logic busy, s_clr_status, s_clr_flags, s_release, flag;

  dfs_reset_seq #(.ADDR_W(ADDR_W), .RESTART_ADDR(RESTART_ADDR)) u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .op_reset_bp_i  (op_reset_bp_i),
    .op_reset_sys_i (op_reset_sys_i),
    .busy_o         (busy),
    .clr_status_o   (s_clr_status),
    .clr_flags_o    (s_clr_flags),
    .clr_psw_o      (clr_psw_o),
    .load_restart_o (load_restart_o),
    .restart_addr_o (restart_addr_o),
    .release_o      (s_release)
  );

  dfs_fault_track #(.N_SEV(N_SEV), .FSR_W(FSR_W)) u_track (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sev_trap_i     (sev_trap_i),
    .trap_cause_i   (trap_cause_i),
    .exit_valid_i   (exit_valid_i),
    .exit_b10_i     (exit_b10_i),
    .exit_b11_i     (exit_b11_i),
    .pf_int_taken_i (pf_int_taken_i),
    .busy_i         (busy),
    .clr_status_i   (s_clr_status),
    .clr_flags_i    (s_clr_flags),
    .release_i      (s_release),
    .flag_o         (flag),
    .pf_gen_o       (pf_int_gen_o),
    .hang_o         (hang_o),
    .fsr_o          (fault_status_o)
  );

  dfs_inhibit #(.N_CP(N_CP)) u_inh (
    .force_i  (flag),
    .psw_pf_i (psw_inh_pf_i),
    .psw_mf_i (psw_inh_mf_i),
    .psw_cp_i (psw_inh_cp_i),
    .pf_o     (inh_pf_o),
    .mf_o     (inh_mf_o),
    .cp_o     (inh_cp_o)
  );

  assign fault_flag_o = flag;
  assign seq_busy_o   = busy;
  assign clr_status_o = s_clr_status;
  assign clr_flags_o  = s_clr_flags;
  assign release_o    = s_release;

  p_forced_inhibit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_flag_o |-> (inh_pf_o && inh_mf_o && (&inh_cp_o)));
  p_status_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_status_o |=> (fault_status_o == '0));
  p_flags_cleared_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_flags_o |=> (!fault_flag_o && !pf_int_gen_o));
  p_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_o |=> !hang_o);
endmodule

// File: tb/dfault_supervisor_test.sv
`timescale 1ns/1ps
module dfault_supervisor_test;
  localparam int unsigned N_CP   = 2;
  localparam int unsigned FSR_W  = 8;
  localparam int unsigned ADDR_W = 17;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [2:0] sev_trap_i = '0;
  logic [FSR_W-1:0] trap_cause_i = '0;
  logic exit_valid_i = 0, exit_b10_i = 0, exit_b11_i = 0, pf_int_taken_i = 0;
  logic op_reset_bp_i = 0, op_reset_sys_i = 0;
  logic psw_inh_pf_i = 0, psw_inh_mf_i = 0;
  logic [N_CP-1:0] psw_inh_cp_i = '0;
  logic fault_flag_o, pf_int_gen_o, hang_o, inh_pf_o, inh_mf_o;
  logic [FSR_W-1:0] fault_status_o;
  logic [N_CP-1:0] inh_cp_o;
  logic clr_status_o, clr_flags_o, clr_psw_o, load_restart_o, release_o, seq_busy_o;
  logic [ADDR_W-1:0] restart_addr_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  dfault_supervisor #(.FSR_W(FSR_W), .N_CP(N_CP), .ADDR_W(ADDR_W)) uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [31:0] strobes();
    return {27'd0, clr_status_o, clr_flags_o, clr_psw_o, load_restart_o, release_o};
  endfunction

  task automatic trap(input logic [2:0] src, input logic [7:0] cause);
    sev_trap_i = src; trap_cause_i = cause;
    tick();
    sev_trap_i = '0; trap_cause_i = '0;
  endtask

  task automatic do_exit(input logic b10, input logic b11);
    exit_valid_i = 1; exit_b10_i = b10; exit_b11_i = b11;
    tick();
    exit_valid_i = 0; exit_b10_i = 0; exit_b11_i = 0;
  endtask

  // full recovery sequence with per-step checks; a trap is injected mid-sequence
  task automatic recover(input logic use_sys, input logic exp_hang);
    if (use_sys) op_reset_sys_i = 1; else op_reset_bp_i = 1;
    tick();
    op_reset_sys_i = 0; op_reset_bp_i = 0;
    chk("R7 step1 strobe", strobes(), 32'b10000);
    op_reset_bp_i = 1;  // ignored while busy (R10)
    tick();
    op_reset_bp_i = 0;
    chk("R7 step2 strobe", strobes(), 32'b01000);
    chk("R8 status cleared", fault_status_o, 0);
    sev_trap_i = 3'b001; trap_cause_i = 8'hEE;  // ignored while busy (R10)
    tick();
    sev_trap_i = '0; trap_cause_i = '0;
    chk("R7 step3 strobe", strobes(), 32'b00100);
    chk("R8 flag cleared", fault_flag_o, 0);
    chk("R8 pf gen cleared", pf_int_gen_o, 0);
    tick();
    chk("R7 step4 strobe", strobes(), 32'b00010);
    chk("R9 restart addr", restart_addr_o, 32'h26);
    tick();
    chk("R7 step5 strobe", strobes(), 32'b00001);
    chk("R5 hang held until release", hang_o, exp_hang);
    tick();
    chk("R7 idle after sequence", strobes(), 0);
    chk("R8 hang released", hang_o, 0);
    chk("R9 addr zero outside load", restart_addr_o, 0);
    chk("R10 trap during sequence ignored flag", fault_flag_o, 0);
    chk("R10 trap during sequence ignored status", fault_status_o, 0);
    chk("R10 busy low", seq_busy_o, 0);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #9;
    rst_ni = 1;
    tick();
    chk("R12 flag", fault_flag_o, 0);
    chk("R12 hang", hang_o, 0);
    chk("R12 status", fault_status_o, 0);
    chk("R12 pf gen", pf_int_gen_o, 0);
    chk("R12 strobes", strobes(), 0);

    // R3 sweep with flag clear
    for (int v = 0; v < 16; v++) begin
      {psw_inh_pf_i, psw_inh_mf_i, psw_inh_cp_i} = v[3:0];
      #1;
      chk("R3 follow psw", {28'd0, inh_pf_o, inh_mf_o, inh_cp_o}, v);
    end

    // exit with flag clear: no effect (R4)
    do_exit(1'b0, 1'b1);
    chk("R4 exit with clear flag", fault_flag_o, 0);

    for (int src = 1; src < 8; src++) begin
      logic [7:0] c1, c2;
      c1 = 8'(src * 37 + 5);
      c2 = ~c1;
      trap(src[2:0], c1);
      chk("R1 flag set", fault_flag_o, 1);
      chk("R2 cause latched", fault_status_o, c1);
      chk("R5 no hang on first", hang_o, 0);
      if (src == 1) begin
        for (int v = 0; v < 16; v++) begin
          {psw_inh_pf_i, psw_inh_mf_i, psw_inh_cp_i} = v[3:0];
          #1;
          chk("R3 forced inhibit", {28'd0, inh_pf_o, inh_mf_o, inh_cp_o}, 32'hF);
        end
        {psw_inh_pf_i, psw_inh_mf_i, psw_inh_cp_i} = '0;
      end
      do_exit(1'b0, 1'b0); chk("R4 exit 00 keeps", fault_flag_o, 1);
      do_exit(1'b1, 1'b0); chk("R4 exit 10 keeps", fault_flag_o, 1);
      do_exit(1'b1, 1'b1); chk("R4 exit 11 keeps", fault_flag_o, 1);
      do_exit(1'b0, 1'b1); chk("R4 exit 01 clears", fault_flag_o, 0);
      chk("R2 status kept after exit", fault_status_o, c1);
      trap(src[2:0], c2);
      chk("R1 flag set again", fault_flag_o, 1);
      chk("R2 later cause ignored", fault_status_o, c1);
      pf_int_taken_i = 1; tick(); pf_int_taken_i = 0;
      chk("R11 pf gen set", pf_int_gen_o, 1);
      if (src[0]) begin
        trap(3'b100, c2);
      end else begin
        // simultaneous trap and qualifying exit (R6)
        sev_trap_i = src[2:0]; trap_cause_i = c2;
        exit_valid_i = 1; exit_b10_i = 0; exit_b11_i = 1;
        tick();
        sev_trap_i = '0; trap_cause_i = '0;
        exit_valid_i = 0; exit_b11_i = 0;
        chk("R6 flag kept on dual", fault_flag_o, 1);
      end
      chk("R5 hang on second", hang_o, 1);
      do_exit(1'b0, 1'b1);
      chk("R5 exit ignored while hung", fault_flag_o, 1);
      chk("R5 hang holds", hang_o, 1);
      recover(src[1], 1'b1);
    end

    // operator reset without a hang still runs the sequence (R7)
    trap(3'b010, 8'h5A);
    recover(1'b0, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule